// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller with Refresh

This block sits between a simple word-request port and an asynchronous DRAM that takes its address in two halves over one shared bus. For each accepted request it puts the row half of the word address on the bus and drops the row strobe. A set number of cycles later it puts the column half on the bus and drops the column strobe. Write-enable and the write data go out one cycle ahead of the column strobe. Read data is taken from the DRAM data input on the last cycle of the column strobe and is handed back with a single-cycle valid pulse.

Once a row is open it stays open. A later request to the same row gets only a fresh column strobe. A request to a different row first raises the row strobe and holds it high for the precharge time. A free-running refresh timer raises a request at a fixed interval. The controller serves that request ahead of any new access as soon as the current access ends. It closes an open row first, then runs a refresh cycle in which the column strobe falls before the row strobe. The DRAM's own row counter chooses which row is refreshed, so no row address is driven.

Top module: `dram_page_ctrl`

## Requirements
- R1: During and right after reset, dram_ras_n, dram_cas_n and dram_we_n are high, dram_dq_oe and rd_valid are low, and req_ready is high.
- R2: For a request that opens a row, dram_addr carries req_addr[15:8] when dram_ras_n falls. dram_cas_n falls exactly T_RCD = 2 cycles later, with req_addr[7:0] on dram_addr.
- R3: Every column strobe of an access holds dram_cas_n low for exactly T_CAS = 2 cycles.
- R4: A request whose row matches the open row leaves dram_ras_n low and produces only one new column strobe. Sixteen same-row accesses started from a closed row produce exactly one row opening.
- R5: Before dram_ras_n falls again, it stays high for at least T_RP = 3 cycles. This covers a change of row.
- R6: On a write, dram_we_n is low and dram_dq_oe is high, with req_wdata on dram_dq_out, in the cycle before dram_cas_n falls and while it is low. On a read, dram_we_n stays high and dram_dq_oe stays low.
- R7: On a read, the value on dram_dq_in in the last column-strobe cycle appears on rd_data. rd_valid is high for exactly one cycle.
- R8: A refresh request is raised every REF_PERIOD = 256 cycles. It is served as a refresh cycle in which dram_cas_n falls while dram_ras_n is high, and dram_ras_n then falls with dram_cas_n still low and dram_we_n high. When the controller is idle, any window of 5 × 256 cycles holds exactly 5 refresh cycles.
- R9: While a refresh is pending, req_ready is low, and any open row is closed with full precharge before the refresh. A continuous stream of requests cannot hold off a refresh beyond 16 cycles past its interval.
- R10: A read returns the data most recently written to the same word address, whatever the order of rows and columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address: row in [15:8], column in [7:0] |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request taken on a cycle where valid and ready are both high |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
The assertions assume that req_addr, req_write and req_wdata hold steady while req_valid is high and until the request is taken. They also assume that dram_dq_in is valid by the last column-strobe cycle. The refresh assertions assume that nothing outside the controller moves the strobes. The bench changes request fields only away from the clock edge and drops req_valid right after acceptance. Its DRAM model returns stored data combinationally from the row and column it latched on the strobe edges, so read data is already stable during the strobe.

// File: rtl/dram_pkg.sv
package dram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAS,
    ST_COLSET,
    ST_CAS,
    ST_OPEN,
    ST_PRE,
    ST_RFCAS,
    ST_RFRAS
  } dstate_t;

  function automatic logic in_col_phase(dstate_t s);
    return (s == ST_COLSET) || (s == ST_CAS);
  endfunction

  function automatic logic row_strobe_low(dstate_t s);
    return (s == ST_RAS) || (s == ST_COLSET) || (s == ST_CAS) ||
           (s == ST_OPEN) || (s == ST_RFRAS);
  endfunction

  function automatic logic col_strobe_low(dstate_t s);
    return (s == ST_CAS) || (s == ST_RFCAS) || (s == ST_RFRAS);
  endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int PERIOD = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] tick_cnt;
  logic          tick;

  assign tick = (tick_cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      pend     <= 1'b0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      if (tick)
        pend <= 1'b1;
      else if (ack)
        pend <= 1'b0;
    end
  end

  // R8: a raised refresh request stays up until it is served
  p_pend_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend);

  // R9: the controller only acknowledges a refresh that is pending
  p_ack_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pend);

endmodule

// File: rtl/dram_open_row.sv
module dram_open_row #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] load_row,
  input  logic             close,
  input  logic [ROW_W-1:0] req_row,
  output logic [ROW_W-1:0] open_row,
  output logic             row_valid,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_row  <= '0;
      row_valid <= 1'b0;
    end else if (load) begin
      open_row  <= load_row;
      row_valid <= 1'b1;
    end else if (close) begin
      row_valid <= 1'b0;
    end
  end

  assign hit = row_valid && (req_row == open_row);

  // R4/R5: a row is never opened and closed in the same cycle
  p_load_close_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && close));

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_pkg::*;
#(
  parameter int ROW_W      = 8,
  parameter int COL_W      = 8,
  parameter int DATA_W     = 16,
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 2,
  parameter int T_RP       = 3,
  parameter int REF_PERIOD = 256
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     req_valid,
  input  logic                                     req_write,
  input  logic [ROW_W+COL_W-1:0]                   req_addr,
  input  logic [DATA_W-1:0]                        req_wdata,
  output logic                                     req_ready,
  output logic                                     rd_valid,
  output logic [DATA_W-1:0]                        rd_data,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                                     dram_ras_n,
  output logic                                     dram_cas_n,
  output logic                                     dram_we_n,
  output logic [DATA_W-1:0]                        dram_dq_out,
  output logic                                     dram_dq_oe,
  input  logic [DATA_W-1:0]                        dram_dq_in
);
  localparam int AW   = ROW_W + COL_W;
  localparam int MW   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TMX1 = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TMAX = (TMX1 > T_RP) ? TMX1 : T_RP;
  localparam int CW   = $clog2(TMAX + 1);

  function automatic logic [ROW_W-1:0] row_of(logic [AW-1:0] a);
    return a[AW-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] col_of(logic [AW-1:0] a);
    return a[COL_W-1:0];
  endfunction

  dstate_t           state, next_state;
  logic [CW-1:0]     cnt, next_cnt;
  logic [AW-1:0]     acc_addr;
  logic              acc_we;
  logic [DATA_W-1:0] acc_wdata;
  logic              acc_miss;

  logic              ref_pend;
  logic              ref_ack;
  logic              accept;
  logic              cnt_done;
  logic              row_load;
  logic              row_close;
  logic [ROW_W-1:0]  load_row;
  logic [ROW_W-1:0]  open_row;
  logic              row_valid;
  logic              page_hit;
  logic              rd_capture;

  dram_refresh_timer #(.PERIOD(REF_PERIOD)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .ack   (ref_ack),
    .pend  (ref_pend)
  );

  assign req_ready = ((state == ST_IDLE) || (state == ST_OPEN)) && !ref_pend;
  assign accept    = req_valid && req_ready;
  assign cnt_done  = (cnt == '0);

  always_comb begin
    next_state = state;
    next_cnt   = cnt;
    ref_ack    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (ref_pend) begin
          next_state = ST_RFCAS;
          next_cnt   = '0;
          ref_ack    = 1'b1;
        end else if (accept) begin
          next_state = ST_RAS;
          next_cnt   = CW'(T_RCD - 2);
        end
      end
      ST_RAS: begin
        if (cnt_done) next_state = ST_COLSET;
        else          next_cnt   = cnt - 1'b1;
      end
      ST_COLSET: begin
        next_state = ST_CAS;
        next_cnt   = CW'(T_CAS - 1);
      end
      ST_CAS: begin
        if (cnt_done) next_state = ST_OPEN;
        else          next_cnt   = cnt - 1'b1;
      end
      ST_OPEN: begin
        if (ref_pend || (accept && !page_hit)) begin
          next_state = ST_PRE;
          next_cnt   = CW'(T_RP - 1);
        end else if (accept) begin
          next_state = ST_COLSET;
        end
      end
      ST_PRE: begin
        if (!cnt_done) begin
          next_cnt = cnt - 1'b1;
        end else if (ref_pend) begin
          next_state = ST_RFCAS;
          next_cnt   = '0;
          ref_ack    = 1'b1;
        end else if (acc_miss) begin
          next_state = ST_RAS;
          next_cnt   = CW'(T_RCD - 2);
        end else begin
          next_state = ST_IDLE;
        end
      end
      ST_RFCAS: begin
        next_state = ST_RFRAS;
        next_cnt   = CW'(T_CAS - 1);
      end
      ST_RFRAS: begin
        if (cnt_done) begin
          next_state = ST_PRE;
          next_cnt   = CW'(T_RP - 1);
        end else begin
          next_cnt = cnt - 1'b1;
        end
      end
      default: next_state = ST_IDLE;
    endcase
  end

  // Row tracking events
  assign row_load  = (next_state == ST_RAS) && (state != ST_RAS);
  assign row_close = (next_state == ST_PRE) && (state != ST_PRE);
  assign load_row  = accept ? row_of(req_addr) : row_of(acc_addr);

  dram_open_row #(.ROW_W(ROW_W)) u_row (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (row_load),
    .load_row  (load_row),
    .close     (row_close),
    .req_row   (row_of(req_addr)),
    .open_row  (open_row),
    .row_valid (row_valid),
    .hit       (page_hit)
  );

  assign rd_capture = (state == ST_CAS) && cnt_done && !acc_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      acc_addr  <= '0;
      acc_we    <= 1'b0;
      acc_wdata <= '0;
      acc_miss  <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      state <= next_state;
      cnt   <= next_cnt;
      if (accept) begin
        acc_addr  <= req_addr;
        acc_we    <= req_write;
        acc_wdata <= req_wdata;
      end
      if (accept && (state == ST_OPEN) && !page_hit)
        acc_miss <= 1'b1;
      else if (row_load)
        acc_miss <= 1'b0;
      rd_valid <= rd_capture;
      if (rd_capture)
        rd_data <= dram_dq_in;
    end
  end

  // DRAM pins decoded from the state register
  always_comb begin
    dram_addr = '0;
    if (state == ST_RAS || state == ST_OPEN)
      dram_addr = MW'(open_row);
    else if (in_col_phase(state))
      dram_addr = MW'(col_of(acc_addr));
  end

  assign dram_ras_n  = !row_strobe_low(state);
  assign dram_cas_n  = !col_strobe_low(state);
  assign dram_we_n   = !(acc_we && in_col_phase(state));
  assign dram_dq_oe  = acc_we && in_col_phase(state);
  assign dram_dq_out = acc_wdata;

  // Precharge run length observed on the row strobe, used by the checks
  logic [CW-1:0] ras_hi_run;
  always_ff @(posedge clk) begin
    if (!rst_n)
      ras_hi_run <= CW'(T_RP);
    else if (!dram_ras_n)
      ras_hi_run <= '0;
    else if (ras_hi_run != CW'(T_RP))
      ras_hi_run <= ras_hi_run + 1'b1;
  end

  // R5/R9: the row strobe only falls after a full precharge
  p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (ras_hi_run == CW'(T_RP)));

  // R6: write enable leads the column strobe of a write
  p_we_leads_cas_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && $fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));

  // R7: read valid is a single-cycle pulse
  p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R8: a column strobe that falls with the row closed is followed by the row strobe
  p_cbr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && dram_ras_n) |=> (!dram_ras_n && !dram_cas_n && dram_we_n));

  // R9: no request is taken while a refresh waits
  p_ready_yields_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ref_pend);

  // R4: a page hit keeps the row strobe low
  p_hit_keeps_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && state == ST_OPEN && page_hit) |=> (!dram_ras_n && row_valid));

endmodule

// File: tb/dram_page_ctrl_test.sv
module dram_page_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD      = 2;
  localparam int T_CAS      = 2;
  localparam int T_RP       = 3;
  localparam int REF_PERIOD = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [7:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [15:0] dram_dq_out;
  logic [15:0] dram_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_page_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Shadow of expected contents and the DRAM model array (rows/cols 0..15)
  logic [15:0] shadow  [0:255];
  logic [15:0] dram_mem[0:255];
  logic [15:0] last_req   = '0;
  logic [15:0] last_wdata = '0;

  // DRAM model state
  int  cyc = 0, ras_hi_len = 100, cas_lo_len = 0, since_ras = 0, last_cbr = -1;
  int  open_cnt = 0, cbr_cnt = 0, cas_cnt = 0;
  bit  fresh = 0, cas_cbr = 0, prev_ras = 1, prev_cas = 1, prev_we = 1;
  logic [7:0] row_lat = '0, col_lat = '0;

  assign dram_dq_in = dram_mem[{row_lat[3:0], col_lat[3:0]}];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_ras && !dram_ras_n) begin
        if (!dram_cas_n) begin
          cbr_cnt++;
          chk(ras_hi_len >= T_RP, "R9 precharge before refresh", ras_hi_len, T_RP);
          chk(dram_we_n == 1'b1, "R8 we_n high in refresh", dram_we_n, 1);
          if (last_cbr >= 0)
            chk((cyc - last_cbr) >= REF_PERIOD - 16 && (cyc - last_cbr) <= REF_PERIOD + 16,
                "R8 refresh interval", cyc - last_cbr, REF_PERIOD);
          last_cbr = cyc;
        end else begin
          open_cnt++;
          chk(ras_hi_len >= T_RP, "R5 precharge length", ras_hi_len, T_RP);
          chk(dram_addr == last_req[15:8], "R2 row address", dram_addr, last_req[15:8]);
          row_lat   = dram_addr;
          fresh     = 1;
          since_ras = 0;
        end
      end else if (!dram_ras_n) begin
        since_ras++;
      end
      if (prev_cas && !dram_cas_n) begin
        cas_lo_len = 1;
        if (dram_ras_n) begin
          cas_cbr = 1;
        end else begin
          cas_cbr = 0;
          cas_cnt++;
          col_lat = dram_addr;
          chk(dram_addr == last_req[7:0], "R2 column address", dram_addr, last_req[7:0]);
          if (fresh) chk(since_ras == T_RCD, "R2 row-to-column delay", since_ras, T_RCD);
          fresh = 0;
          if (!dram_we_n) begin
            chk(!prev_we && dram_dq_oe, "R6 write enable leads CAS", prev_we, 0);
            chk(dram_dq_out == last_wdata, "R6 write data", dram_dq_out, last_wdata);
            dram_mem[{row_lat[3:0], col_lat[3:0]}] = dram_dq_out;
          end else begin
            chk(!dram_dq_oe, "R6 read leaves bus undriven", dram_dq_oe, 0);
          end
        end
      end else if (!dram_cas_n) begin
        cas_lo_len++;
      end
      if (!prev_cas && dram_cas_n && !cas_cbr)
        chk(cas_lo_len == T_CAS, "R3 CAS pulse width", cas_lo_len, T_CAS);
      ras_hi_len = dram_ras_n ? ras_hi_len + 1 : 0;
    end
    prev_ras = dram_ras_n;
    prev_cas = dram_cas_n;
    prev_we  = dram_we_n;
  end

  task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    last_req = a;
    if (wr) begin
      last_wdata = d;
      shadow[{a[11:8], a[3:0]}] = d;
    end
    #1;
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    bit got = 0;
    issue(1'b0, a, 16'h0);
    for (int n = 0; n < 80 && !got; n++) begin
      @(negedge clk);
      if (rd_valid) got = 1;
    end
    chk(got, {tag, " read returned"}, got, 1);
    chk(rd_data == shadow[{a[11:8], a[3:0]}], tag, rd_data, shadow[{a[11:8], a[3:0]}]);
    @(negedge clk);
    chk(!rd_valid, "R7 valid lasts one cycle", rd_valid, 0);
  endtask

  function automatic logic [15:0] pattern(int r, int c);
    return 16'((r * 37 + c * 11 + 5) * 131);
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) begin
      shadow[i]   = '0;
      dram_mem[i] = '0;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    int base_open, base_cas, base_cbr, t0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle in reset",
        {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(!dram_dq_oe && !rd_valid, "R1 outputs quiet in reset", {dram_dq_oe, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk(dram_ras_n && dram_cas_n, "R1 strobes idle after reset", {dram_ras_n, dram_cas_n}, 3);

    // R10/R4: row-major write sweep (page hits within each row)
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        issue(1'b1, 16'((r << 8) | c), pattern(r, c));

    // R10/R5: column-major read sweep (every access changes row)
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 16; r++)
        do_read(16'((r << 8) | c), "R10 read after write (row change)");

    // R7/R10: row-major reads (page hits)
    for (int r = 0; r < 16; r += 3)
      for (int c = 0; c < 16; c++)
        do_read(16'((r << 8) | c), "R7 read data on page hit");

    // R4: sixteen same-row writes right after a refresh open the row once
    base_cbr = cbr_cnt;
    while (cbr_cnt == base_cbr) @(negedge clk);
    repeat (8) @(negedge clk);
    base_open = open_cnt;
    base_cas  = cas_cnt;
    for (int c = 0; c < 16; c++)
      issue(1'b1, 16'((9 << 8) | c), pattern(c, 9) ^ 16'h5a5a);
    repeat (8) @(negedge clk);
    chk(open_cnt - base_open == 1, "R4 single row opening for page hits", open_cnt - base_open, 1);
    chk(cas_cnt - base_cas == 16, "R4 one column strobe per access", cas_cnt - base_cas, 16);
    for (int c = 0; c < 16; c += 5)
      do_read(16'((9 << 8) | c), "R10 rewritten row");

    // R8: idle window holds exactly five refreshes
    repeat (20) @(negedge clk);
    base_cbr = cbr_cnt;
    repeat (5 * REF_PERIOD) @(negedge clk);
    chk(cbr_cnt - base_cbr == 5, "R8 refresh count while idle", cbr_cnt - base_cbr, 5);

    // R9: a continuous request stream does not hold off refresh
    base_cbr = cbr_cnt;
    t0 = cyc;
    for (int i = 0; cyc - t0 < 700; i++)
      issue(1'b1, 16'((3 << 8) | (i % 16)), 16'(i * 7 + 1));
    chk(cbr_cnt - base_cbr >= 2, "R9 refresh served under load", cbr_cnt - base_cbr, 2);
    do_read(16'h0305, "R10 read after stream");

    repeat (10) @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule